// File: doc/BRIEF.md
# Cascadable Sixteen-Request Priority Encoder

This block turns a set of request lines into the binary index of the most important one. It is built from identical eight-request encoder stages. Each stage has an enable input and two status outputs. One status output says that the stage found a request. The other says that the stage was enabled but found nothing, and it enables the next, less important stage in the chain. The top level joins two stages into a sixteen-request encoder with a four-bit index.

Every pin is active low: a request, the enable and each status flag are asserted at logic 0, and the index is delivered inverted. The logic is purely combinational, so outputs follow the inputs within the same cycle. A user decodes the index only when the group flag is low, because an enabled encoder with no requests and an encoder whose only request is on line 0 give the same index bits.

Top module: `prio_enc16`

## Requirements
- R1: With the encoder enabled, the reported index is the highest-numbered asserted request; line 15 beats every other line.
- R2: Requests and enable are asserted at 0, and the index is driven inverted: request k alone gives `idx_n` equal to the bitwise complement of k.
- R3: `gs_n` is 0 exactly when `en_n` is 0 and at least one request is asserted.
- R4: `eo_n` is 0 exactly when `en_n` is 0 and no request is asserted.
- R5: With `en_n` at 1, `idx_n` is all ones and `gs_n` and `eo_n` are both 1, whatever the requests.
- R6: Enabled with no request, `idx_n` reads all ones and `gs_n` reads 1; a lone request on line 0 also gives `idx_n` all ones but `gs_n` 0.
- R7: Any asserted request on lines 8 to 15 takes priority over all of lines 0 to 7 and drives `idx_n[3]` to 0.
- R8: The lower stage encodes lines 0 to 7 only when the upper stage is enabled and idle; then `idx_n[3]` is 1 and the low bits give the lower line's number inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Request lines, active low; line 15 is most important |
| en_n | input | 1 | Encoder enable, active low |
| idx_n | output | 4 | Index of the winning request, inverted |
| gs_n | output | 1 | Low when enabled and some request is present |
| eo_n | output | 1 | Low when enabled and no request is present; chains to a further stage |

## Verification
A faulty grant term or code mapping shows up at the ports in the same cycle as a wrong index for specific request patterns. The full sweep of all sixteen-bit request patterns with the encoder enabled therefore exposes every bad term. A broken enable chain between the stages shows as both stages claiming a request, or as the lower stage staying silent. It appears as soon as upper lines go idle while lower lines are asserted. Disabled-mode faults show as any output leaving logic 1 under some request pattern.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int STAGE_W_DEF = 8;

  // true when bit b of index idx is set
  function automatic logic idx_bit(int idx, int b);
    return ((idx >> b) & 1) != 0;
  endfunction
endpackage

// File: rtl/pe_grant.sv
module pe_grant #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant,
  output logic         any
);
  logic [W:0] above;

  assign above[W] = 1'b0;

  generate
    for (genvar i = W - 1; i >= 0; i--) begin : g_term
      assign above[i] = above[i+1] | req[i];
      assign grant[i] = req[i] & ~above[i+1];
    end
  endgenerate

  assign any = above[0];

  always_comb begin
    // R1
    onehot_grant_chk: assert ($onehot0(grant))
      else $error("grant vector is not one-hot");
    // R3
    grant_any_chk: assert ((|grant) == (|req))
      else $error("grant presence disagrees with requests");
  end
endmodule

// File: rtl/pe_code.sv
module pe_code #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  grant,
  output logic [CW-1:0] code
);
  import pe_pkg::*;

  generate
    for (genvar b = 0; b < CW; b++) begin : g_bit
      logic [W-1:0] sel;
      for (genvar i = 0; i < W; i++) begin : g_sel
        assign sel[i] = idx_bit(i, b) & grant[i];
      end
      assign code[b] = |sel;
    end
  endgenerate
endmodule

// File: rtl/pe_stage.sv
module pe_stage #(
  parameter int W  = 8,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  req_n,
  input  logic          en_n,
  output logic [CW-1:0] code_n,
  output logic          gs_n,
  output logic          eo_n
);
  logic [W-1:0]  req;
  logic [W-1:0]  grant;
  logic          any;
  logic          en;
  logic [CW-1:0] code;

  assign req = ~req_n;
  assign en  = ~en_n;

  pe_grant #(.W(W)) u_grant (
    .req   (req),
    .grant (grant),
    .any   (any)
  );

  pe_code #(.W(W), .CW(CW)) u_code (
    .grant (grant),
    .code  (code)
  );

  assign code_n = (en && any) ? ~code : '1;
  assign gs_n   = ~(en & any);
  assign eo_n   = ~(en & ~any);

  always_comb begin
    // R5
    off_quiet_chk: assert (!en_n || (&code_n && gs_n && eo_n))
      else $error("disabled stage drives an output");
    // R4
    flag_excl_chk: assert (en_n || (gs_n != eo_n))
      else $error("enabled stage flags not exclusive");
    // R6
    idle_code_chk: assert (!gs_n || (&code_n))
      else $error("index driven without a request");
  end
endmodule

// File: rtl/prio_enc16.sv
module prio_enc16 #(
  parameter  int STAGE_W = pe_pkg::STAGE_W_DEF,
  localparam int CW      = $clog2(STAGE_W)
) (
  input  logic [2*STAGE_W-1:0] req_n,
  input  logic                 en_n,
  output logic [CW:0]          idx_n,
  output logic                 gs_n,
  output logic                 eo_n
);
  logic [CW-1:0] hi_code_n;
  logic [CW-1:0] lo_code_n;
  logic          hi_gs_n;
  logic          hi_eo_n;
  logic          lo_gs_n;
  logic          lo_eo_n;

  pe_stage #(.W(STAGE_W), .CW(CW)) u_hi (
    .req_n  (req_n[2*STAGE_W-1:STAGE_W]),
    .en_n   (en_n),
    .code_n (hi_code_n),
    .gs_n   (hi_gs_n),
    .eo_n   (hi_eo_n)
  );

  // lower stage is enabled only by an idle upper stage
  pe_stage #(.W(STAGE_W), .CW(CW)) u_lo (
    .req_n  (req_n[STAGE_W-1:0]),
    .en_n   (hi_eo_n),
    .code_n (lo_code_n),
    .gs_n   (lo_gs_n),
    .eo_n   (lo_eo_n)
  );

  // active-low OR of the two codes is an AND
  assign idx_n = {hi_gs_n, hi_code_n & lo_code_n};
  assign gs_n  = hi_gs_n & lo_gs_n;
  assign eo_n  = lo_eo_n;

  always_comb begin
    // R7
    one_stage_chk: assert (hi_gs_n || lo_gs_n)
      else $error("both stages claim a request");
    // R8
    lo_gated_chk: assert (!(~&req_n[2*STAGE_W-1:STAGE_W] && !en_n) || lo_gs_n)
      else $error("lower stage active while upper has a request");
  end
endmodule

// File: tb/prio_enc16_test.sv
`timescale 1ns/1ps
module prio_enc16_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] req_n = '1;
  logic        en_n = 1'b1;
  logic [3:0]  idx_n;
  logic        gs_n;
  logic        eo_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [15:0] req_n;
    logic        en_n;
    logic [3:0]  idx_n;
    logic        gs_n;
    logic        eo_n;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  prio_enc16 uut (
    .req_n (req_n),
    .en_n  (en_n),
    .idx_n (idx_n),
    .gs_n  (gs_n),
    .eo_n  (eo_n)
  );

  // reference: scan from line 15 downward
  function automatic exp_t model(logic [15:0] r_n, logic e_n);
    exp_t e;
    bit   found = 1'b0;
    int   win = 0;
    for (int k = 15; k >= 0; k--) begin
      if (!found && r_n[k] == 1'b0) begin
        found = 1'b1;
        win = k;
      end
    end
    e.req_n = r_n;
    e.en_n  = e_n;
    e.idx_n = (!e_n && found) ? ~4'(win) : 4'hF;
    e.gs_n  = !(!e_n && found);
    e.eo_n  = !(!e_n && !found);
    return e;
  endfunction

  task automatic drive(logic [15:0] r_n, logic e_n);
    @(posedge clk);
    req_n = r_n;
    en_n  = e_n;
    sb.push_back(model(r_n, e_n));
  endtask

  // monitor: compare half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        string tag;
        e = sb.pop_front();
        if (e.en_n) tag = "R5";
        else if (&e.req_n) tag = "R6";
        else if (~&e.req_n[15:8]) tag = "R7";
        else tag = "R8";
        // index: R1 and R2 across all enabled patterns
        checks++;
        if (idx_n !== e.idx_n) begin
          errors++;
          $display("FAIL %s R1 idx_n req_n=%h en_n=%b actual=%h expected=%h",
                   tag, e.req_n, e.en_n, idx_n, e.idx_n);
        end
        checks++;
        if (gs_n !== e.gs_n) begin
          errors++;
          $display("FAIL R3 %s gs_n req_n=%h en_n=%b actual=%b expected=%b",
                   tag, e.req_n, e.en_n, gs_n, e.gs_n);
        end
        checks++;
        if (eo_n !== e.eo_n) begin
          errors++;
          $display("FAIL R4 %s eo_n req_n=%h en_n=%b actual=%b expected=%b",
                   tag, e.req_n, e.en_n, eo_n, e.eo_n);
        end
      end
    end
  end

  // watchdog
  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // reset state: idle and disabled (R5)
    drive(16'hFFFF, 1'b1);
    // R6: enabled with no request versus lone request on line 0
    drive(16'hFFFF, 1'b0);
    drive(16'hFFFE, 1'b0);
    // R1, R2: every line asserted, line 15 wins -> idx_n 0000
    drive(16'h0000, 1'b0);
    // R2: each line alone
    for (int k = 0; k < 16; k++) drive(~(16'h1 << k), 1'b0);
    // R7: upper line 8 with lower lines present
    drive(16'hFE00, 1'b0);
    // R8: lower line 5 only
    drive(16'hFFDF, 1'b0);
    // R5: disabled, many request patterns
    for (int k = 0; k < 256; k++) drive({8'(k), 8'(255 - k)}, 1'b1);
    // R1, R7, R8: full enabled sweep
    for (int k = 0; k < 65536; k++) drive(16'(k), 1'b0);
    @(posedge clk);
    @(posedge clk);
    while (sb.size() > 0) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule